// File: doc/BRIEF.md
# Serial Command Handler for Sine/Cosine Core Testing

This block turns a stream of received UART bytes into work for two external sine/cosine engines. A command is a two-byte header: a fixed marker byte, then a code byte. Two codes carry a 32-bit phase word, least significant byte first. That phase is handed to one of the two engines with a single-cycle start pulse. The block waits for the chosen engine's done pulse and captures both results. It then streams them back as eight bytes: sine first, then cosine, each least significant byte first.

Two further codes switch a clock-enable modulation mode on and off. While the mode is on, the enable driven to the engines toggles on every cycle. While it is off, the enable stays high. Four status flags show the block's state: idle and waiting for a command, calculating, modulation active, and transmitting.

The UART bit timing lives outside the block. Its receiver delivers one byte with a one-cycle `rx_valid` strobe. Its transmitter takes a byte on any cycle where both `tx_valid` and `tx_ready` are high.

Top module: `sincos_cmd_ctrl`

## Requirements
- R1: After synchronous active-high reset, `stat_ready`=1, `stat_calc`=0, `stat_txbusy`=0, `stat_clkmod`=0, `eng_clk_en`=1, `tx_valid`=0 and both start outputs are 0.
- R2: While the block waits for a command, any received byte other than the marker 0x41 is dropped and the block keeps waiting. A complete command that follows such a byte is still accepted.
- R3: The sequence 0x41, 0x42, p0, p1, p2, p3 drives `eng_phase`={p3,p2,p1,p0} and raises `eng0_start` for exactly one cycle. `eng1_start` stays 0.
- R4: The sequence 0x41, 0x43 followed by four phase bytes does the same, but on `eng1_start`, with `eng0_start` staying 0.
- R5: When the selected engine signals done, exactly eight bytes are sent. They are sin[7:0], sin[15:8], sin[23:16], sin[31:24], then cos[7:0], cos[15:8], cos[23:16], cos[31:24].
- R6: `eng_phase` holds its value from the start pulse until the done pulse. The results are captured on the done cycle. A done pulse from the engine that was not selected is ignored.
- R7: 0x41, 0x44 sets `stat_clkmod` and 0x41, 0x45 clears it. Neither command sends any reply byte or pulses a start output.
- R8: While `stat_clkmod` is 1, `eng_clk_en` alternates value on every cycle, starting low in the first cycle of the mode. While it is 0, `eng_clk_en` is 1.
- R9: A code byte other than 0x42 to 0x45 after a marker returns the block to waiting, with no reply and no start. The next byte is then treated as a marker candidate.
- R10: A byte is transferred only on a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R11: Exactly one of `stat_ready`, `stat_calc` and `stat_txbusy` is high. `stat_calc` is high from the start pulse until the done pulse. `stat_ready` returns one cycle after the eighth byte is accepted.
- R12: Bytes received while calculating or transmitting are dropped and cannot change the mode or start a command.
- R13: Reset in the middle of an operation clears the modulation mode and the calculating and transmitting flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | A reply byte is offered |
| tx_data | output | 8 | Reply byte |
| eng_phase | output | DW | Phase word to the engines |
| eng_clk_en | output | 1 | Clock enable to the engines |
| eng0_start | output | 1 | Start pulse, narrow engine |
| eng0_done | input | 1 | Done pulse, narrow engine |
| eng0_sin | input | DW | Sine result, narrow engine |
| eng0_cos | input | DW | Cosine result, narrow engine |
| eng1_start | output | 1 | Start pulse, wide engine |
| eng1_done | input | 1 | Done pulse, wide engine |
| eng1_sin | input | DW | Sine result, wide engine |
| eng1_cos | input | DW | Cosine result, wide engine |
| stat_ready | output | 1 | Waiting for a command |
| stat_calc | output | 1 | Calculation in progress |
| stat_clkmod | output | 1 | Clock-enable modulation on |
| stat_txbusy | output | 1 | Reply being sent |

## Verification
The bench builds the block with its default parameters: a 32-bit data width and the codes 0x41 to 0x45. This gives a four-byte phase and an eight-byte reply.

The engine stub answers 20 cycles after a start, using a different result function for each engine. That gap is wide enough to inject a whole command while a calculation runs. Because each engine has its own function, a reply from the wrong engine shows up in the data.

A transmit-ready pattern that stalls one cycle in every three exercises holding a byte under backpressure. That includes a stall on the eighth byte.

// File: rtl/sincos_cmd_ctrl.sv
module sincos_cmd_ctrl #(
  parameter int          DW        = 32,
  parameter logic [7:0]  MARKER    = 8'h41,
  parameter logic [7:0]  C_ENG0    = 8'h42,
  parameter logic [7:0]  C_ENG1    = 8'h43,
  parameter logic [7:0]  C_MOD_ON  = 8'h44,
  parameter logic [7:0]  C_MOD_OFF = 8'h45
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic [DW-1:0] eng_phase,
  output logic          eng_clk_en,
  output logic          eng0_start,
  input  logic          eng0_done,
  input  logic [DW-1:0] eng0_sin,
  input  logic [DW-1:0] eng0_cos,
  output logic          eng1_start,
  input  logic          eng1_done,
  input  logic [DW-1:0] eng1_sin,
  input  logic [DW-1:0] eng1_cos,
  output logic          stat_ready,
  output logic          stat_calc,
  output logic          stat_clkmod,
  output logic          stat_txbusy
);
  localparam int NB = DW / 8;
  localparam int RB = 2 * NB;
  localparam int CW = $clog2(RB + 1);

  typedef enum logic [2:0] {S_MARK, S_CODE, S_PHASE, S_START, S_WAIT, S_TX} st_t;

  st_t            st;
  logic           sel;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  phase;
  logic [2*DW-1:0] reply;
  logic           mod_on;
  logic           tog;

  wire            tx_fire  = tx_valid && tx_ready;
  wire            res_done = sel ? eng1_done : eng0_done;
  wire [DW-1:0]   res_sin  = sel ? eng1_sin  : eng0_sin;
  wire [DW-1:0]   res_cos  = sel ? eng1_cos  : eng0_cos;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_MARK;
      sel    <= 1'b0;
      cnt    <= '0;
      phase  <= '0;
      reply  <= '0;
      mod_on <= 1'b0;
      tog    <= 1'b0;
    end else begin
      tog <= mod_on ? ~tog : 1'b0;
      case (st)
        S_MARK:
          if (rx_valid && rx_data == MARKER) st <= S_CODE;
        S_CODE:
          if (rx_valid) begin
            cnt <= '0;
            if (rx_data == C_ENG0) begin
              sel <= 1'b0;
              st  <= S_PHASE;
            end else if (rx_data == C_ENG1) begin
              sel <= 1'b1;
              st  <= S_PHASE;
            end else begin
              if (rx_data == C_MOD_ON)  mod_on <= 1'b1;
              if (rx_data == C_MOD_OFF) mod_on <= 1'b0;
              st <= S_MARK;
            end
          end
        S_PHASE:
          if (rx_valid) begin
            phase <= {rx_data, phase[DW-1:8]};
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(NB - 1)) st <= S_START;
          end
        S_START:
          st <= S_WAIT;
        S_WAIT:
          if (res_done) begin
            reply <= {res_cos, res_sin};
            cnt   <= '0;
            st    <= S_TX;
          end
        S_TX:
          if (tx_fire) begin
            reply <= reply >> 8;
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(RB - 1)) st <= S_MARK;
          end
        default:
          st <= S_MARK;
      endcase
    end
  end

  assign eng_phase   = phase;
  assign eng0_start  = (st == S_START) && !sel;
  assign eng1_start  = (st == S_START) &&  sel;
  assign eng_clk_en  = !mod_on || tog;
  assign tx_valid    = (st == S_TX);
  assign tx_data     = reply[7:0];
  assign stat_ready  = (st == S_MARK) || (st == S_CODE) || (st == S_PHASE);
  assign stat_calc   = (st == S_START) || (st == S_WAIT);
  assign stat_clkmod = mod_on;
  assign stat_txbusy = (st == S_TX);
endmodule

// File: rtl/sincos_cmd_ctrl_chk.sv
module sincos_cmd_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic [DW-1:0] eng_phase,
  input logic          eng_clk_en,
  input logic          eng0_start,
  input logic          eng1_start,
  input logic          stat_ready,
  input logic          stat_calc,
  input logic          stat_clkmod,
  input logic          stat_txbusy
);
  assert_start_excl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eng0_start, eng1_start}));

  assert_start_pulse0_R3: assert property (@(posedge clk) disable iff (rst)
    eng0_start |=> !eng0_start);

  assert_start_pulse1_R4: assert property (@(posedge clk) disable iff (rst)
    eng1_start |=> !eng1_start);

  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (rst)
    stat_calc |=> (!stat_calc || $stable(eng_phase)));

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_flags_one_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot({stat_ready, stat_calc, stat_txbusy}));

  assert_start_calc_R11: assert property (@(posedge clk) disable iff (rst)
    (eng0_start || eng1_start) |-> stat_calc);

  assert_clken_off_R8: assert property (@(posedge clk) disable iff (rst)
    !stat_clkmod |-> eng_clk_en);

  assert_clken_alt_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_clkmod && $past(stat_clkmod)) |-> (eng_clk_en != $past(eng_clk_en)));

  assert_clken_first_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_clkmod) |-> !eng_clk_en);
endmodule

bind sincos_cmd_ctrl sincos_cmd_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/sincos_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module sincos_cmd_ctrl_bench;
  localparam int DW  = 32;
  localparam int LAT = 20;

  logic clk = 0, rst = 1;
  logic rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic tx_ready = 1, tx_valid;
  logic [7:0] tx_data;
  logic [DW-1:0] eng_phase;
  logic eng_clk_en, eng0_start, eng1_start;
  logic eng0_done = 0, eng1_done = 0;
  logic [DW-1:0] eng0_sin = 0, eng0_cos = 0, eng1_sin = 0, eng1_cos = 0;
  logic stat_ready, stat_calc, stat_clkmod, stat_txbusy;

  int checks = 0, errors = 0;
  int starts0 = 0, starts1 = 0, nbytes = 0, cyc = 0, pcnt = 0;
  logic [7:0] rxb [0:15];
  logic stall_mode = 0;
  logic [DW-1:0] ph0, ph1;
  int cnt0 = 0, cnt1 = 0;

  always #2 clk = ~clk;

  sincos_cmd_ctrl u_sincos_cmd_ctrl (.*);

  function automatic logic [DW-1:0] f0s(logic [DW-1:0] p); return p ^ 32'h1234_5678; endfunction
  function automatic logic [DW-1:0] f0c(logic [DW-1:0] p); return ~p; endfunction
  function automatic logic [DW-1:0] f1s(logic [DW-1:0] p); return p + 32'h0101_0101; endfunction
  function automatic logic [DW-1:0] f1c(logic [DW-1:0] p); return {p[15:0], p[31:16]}; endfunction

  // engine stubs
  always @(posedge clk) begin
    eng0_done <= 0;
    eng1_done <= 0;
    if (eng0_start) begin starts0++; ph0 <= eng_phase; cnt0 <= LAT; end
    else if (cnt0 > 0) begin
      cnt0 <= cnt0 - 1;
      if (cnt0 == 1) begin eng0_done <= 1; eng0_sin <= f0s(ph0); eng0_cos <= f0c(ph0); end
    end
    if (eng1_start) begin starts1++; ph1 <= eng_phase; cnt1 <= LAT; end
    else if (cnt1 > 0) begin
      cnt1 <= cnt1 - 1;
      if (cnt1 == 1) begin eng1_done <= 1; eng1_sin <= f1s(ph1); eng1_cos <= f1c(ph1); end
    end
  end

  // transmitter ready pattern
  always @(posedge clk) begin
    #1;
    pcnt++;
    tx_ready = stall_mode ? (pcnt % 3 != 0) : 1'b1;
  end

  // reply monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst && tx_valid && tx_ready) begin
      if (nbytes < 16) rxb[nbytes] = tx_data;
      nbytes++;
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1; idle(3); rst = 0; idle(1);
  endtask

  task automatic run_calc(string tag, logic [7:0] code, logic [DW-1:0] p, bit eng1);
    int s0 = starts0, s1 = starts1;
    logic [DW-1:0] es, ec;
    nbytes = 0;
    send(8'h41); send(code);
    send(p[7:0]); send(p[15:8]); send(p[23:16]); send(p[31:24]);
    chk({tag, " R11 calc flag"}, stat_calc, 1);
    chk({tag, " R3 phase word"}, eng_phase, p);
    idle(5);
    chk({tag, " R6 phase held"}, eng_phase, p);
    for (int i = 0; i < 400 && nbytes < 8; i++) @(negedge clk);
    idle(1);
    chk({tag, " R11 ready after reply"}, stat_ready, 1);
    idle(3);
    chk({tag, " R5 byte count"}, nbytes, 8);
    chk({tag, " R3 eng0 starts"}, starts0 - s0, eng1 ? 0 : 1);
    chk({tag, " R4 eng1 starts"}, starts1 - s1, eng1 ? 1 : 0);
    es = eng1 ? f1s(p) : f0s(p);
    ec = eng1 ? f1c(p) : f0c(p);
    chk({tag, " R5 sine"}, {rxb[3], rxb[2], rxb[1], rxb[0]}, es);
    chk({tag, " R5 cosine"}, {rxb[7], rxb[6], rxb[5], rxb[4]}, ec);
  endtask

  task automatic t_reset;
    chk("R1 ready", stat_ready, 1);
    chk("R1 calc", stat_calc, 0);
    chk("R1 txbusy", stat_txbusy, 0);
    chk("R1 clkmod", stat_clkmod, 0);
    chk("R1 clk_en", eng_clk_en, 1);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 starts", {eng0_start, eng1_start}, 0);
  endtask

  task automatic t_marker;
    int s = starts0 + starts1;
    send(8'h55); send(8'h42); send(8'h00); send(8'hFF);
    idle(30);
    chk("R2 junk no start", starts0 + starts1 - s, 0);
    chk("R2 junk no reply", nbytes, 0);
    chk("R2 still ready", stat_ready, 1);
    send(8'h13);
    run_calc("R2 after junk", 8'h42, 32'hCAFE_0001, 0);
  endtask

  task automatic t_mode;
    int s = starts0 + starts1;
    logic prev;
    nbytes = 0;
    send(8'h41); send(8'h44);
    chk("R7 mode on", stat_clkmod, 1);
    prev = eng_clk_en;
    chk("R8 first low", prev, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 alternates", eng_clk_en, !prev);
      prev = eng_clk_en;
    end
    send(8'h41); send(8'h45);
    chk("R7 mode off", stat_clkmod, 0);
    chk("R8 enable high", eng_clk_en, 1);
    idle(10);
    chk("R7 no reply", nbytes, 0);
    chk("R7 no start", starts0 + starts1 - s, 0);
  endtask

  task automatic t_unknown;
    int s = starts0 + starts1;
    nbytes = 0;
    send(8'h41); send(8'h47);
    chk("R9 back to wait", stat_ready, 1);
    send(8'h42); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
    idle(30);
    chk("R9 no start", starts0 + starts1 - s, 0);
    chk("R9 no reply", nbytes, 0);
  endtask

  task automatic t_busy_ignore;
    nbytes = 0;
    send(8'h41); send(8'h43);
    send(8'h10); send(8'h20); send(8'h30); send(8'h40);
    idle(2);
    send(8'h41); send(8'h44);
    chk("R12 mode untouched", stat_clkmod, 0);
    for (int i = 0; i < 200 && nbytes < 8; i++) @(negedge clk);
    idle(3);
    chk("R12 reply intact", {rxb[3], rxb[2], rxb[1], rxb[0]}, f1s(32'h4030_2010));
    chk("R12 mode still off", stat_clkmod, 0);
  endtask

  task automatic t_stall;
    stall_mode = 1;
    run_calc("R10 stalled", 8'h43, 32'h89AB_CDEF, 1);
    stall_mode = 0;
  endtask

  task automatic t_midreset;
    send(8'h41); send(8'h44);
    send(8'h41); send(8'h42);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    idle(3);
    chk("R13 calc before reset", stat_calc, 1);
    do_reset();
    chk("R13 mode cleared", stat_clkmod, 0);
    chk("R13 calc cleared", stat_calc, 0);
    chk("R13 txbusy cleared", stat_txbusy, 0);
    chk("R13 ready", stat_ready, 1);
    idle(40);
    chk("R13 no stray tx", tx_valid, 0);
  endtask

  initial begin
    idle(1);
    do_reset();
    t_reset();
    t_marker();
    run_calc("R3 eng0", 8'h42, 32'h0403_0201, 0);
    run_calc("R4 eng1", 8'h43, 32'hDEAD_BEEF, 1);
    t_mode();
    t_unknown();
    t_busy_ignore();
    t_stall();
    t_midreset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule